// File: doc/BRIEF.md
# Block Instruction Repeat Unit

This unit sits at the end of every iteration of a repeating block instruction of an 8-bit CPU: block copy, block compare, and block input or output. When the iteration ends, the core pulses `eval` with a 2-bit condition selector, a flag that marks whether this is the repeating or the single-shot form, the updated BC pair, the zero flag and the current program counter. The unit decides whether the instruction runs again. The data movement and flag logic of the instruction are handled elsewhere.

If the instruction does not repeat, the unit releases the core to a normal opcode fetch in the same cycle. Interrupts may be taken at that fetch. If it repeats, a fixed rewind sequence runs. That sequence walks the program counter back by two, so the same instruction is fetched again. For the copy and compare selectors it also loads the WZ register with PC+1. Interrupts are only honoured at a fetch boundary and never inside the rewind.

The sequencer has six states:
- `ST_IDLE` waits for `eval`.
- `ST_GAP1` is an idle slot.
- `ST_DEC1` decrements PC.
- `ST_GAP2` is an idle slot.
- `ST_DEC2` decrements PC.
- `ST_FETCH` is the fetch boundary.

Its transitions are:
- repeat-start: `ST_IDLE` to `ST_GAP1`, on `eval` with the repeat condition true.
- stay: `ST_IDLE` to `ST_IDLE`, otherwise.
- `ST_GAP1` to `ST_DEC1`, `ST_DEC1` to `ST_GAP2`, `ST_GAP2` to `ST_DEC2` and `ST_DEC2` to `ST_FETCH`, all unconditionally.
- release: `ST_FETCH` to `ST_IDLE`.

Top module: `block_repeat_unit`

## Requirements
- R1: After reset `busy`, `pc_dec`, `fetch_go`, `rep_taken` and `irq_take` are 0 and `wz_q` is 0x0000.
- R2: With `repeat_en`=1 and `sel`=0, `rep_taken` is high in the `eval` cycle exactly when BC (bc[15:0]) is nonzero.
- R3: With `repeat_en`=1 and `sel`=1, `rep_taken` is high exactly when BC is nonzero and `zf` is 0.
- R4: With `repeat_en`=1 and `sel`=2 or 3, `rep_taken` is high exactly when B (bc[15:8]) is nonzero.
- R5: With `repeat_en`=0, `rep_taken` stays 0 for any selector and operands, `fetch_go` is high in the `eval` cycle, and `busy` stays 0 afterwards.
- R6: Suppose a repeat is taken in cycle t.
  - `busy` is high in cycles t+1 to t+5.
  - `pc_dec` is high in t+2 and t+4 only.
  - In t+5, `fetch_go` is high and `pc_value` equals the sampled PC minus 2, modulo 2^16.
  - In t+6, `busy` is 0.
- R7: A repeat with `sel` 0 or 1 loads `wz_q` with the sampled PC plus 1, modulo 2^16. A repeat with `sel` 2 or 3 leaves `wz_q` unchanged, and so does a non-repeat.
- R8: When `eval` does not repeat, `fetch_go` is high in that same cycle and `pc_value` equals `pc`.
- R9: `irq_take` equals `irq_pend` in any cycle with `fetch_go` high, and is 0 in every other cycle, including the whole rewind.
- R10: While `busy` is high, `eval` is ignored. No new repeat starts, and the sequence timing, `pc_value` and `wz_q` are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval | input | 1 | End-of-iteration strobe |
| sel | input | 2 | Termination test selector |
| repeat_en | input | 1 | 1 = repeating form, 0 = single-shot form |
| bc | input | 16 | BC pair after this iteration (B in the high byte) |
| zf | input | 1 | Zero flag after this iteration |
| pc | input | 16 | Current program counter |
| irq_pend | input | 1 | An interrupt is pending |
| rep_taken | output | 1 | Repeat decided (in the `eval` cycle) |
| busy | output | 1 | Rewind sequence in progress |
| pc_dec | output | 1 | PC decrement slot |
| fetch_go | output | 1 | Opcode fetch boundary |
| pc_value | output | 16 | Fetch address / PC as rewound |
| wz_q | output | 16 | WZ register |
| irq_take | output | 1 | Interrupt accepted at this boundary |

## Verification
The hardest case to reach is `eval` and a pending interrupt arriving in the middle of a rewind, where both must be ignored. The stimulus holds `eval` high with fresh random operands, and keeps `irq_pend` high, through every rewind slot. It then checks that no second repeat starts, that `wz_q` does not move, and that `irq_take` appears only at the closing fetch. The directed cases cover the decision edges: BC of 0x0001, a B of zero with a nonzero C, and PC values of 0x0001 and 0xFFFF, whose rewind and WZ load wrap.

// File: rtl/blkrep_pkg.sv
package blkrep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP1,
        ST_DEC1,
        ST_GAP2,
        ST_DEC2,
        ST_FETCH
    } seq_state_t;

    localparam logic [1:0] SEL_PAIR      = 2'd0;
    localparam logic [1:0] SEL_PAIR_NZ   = 2'd1;
    localparam logic [1:0] SEL_HIGH_A    = 2'd2;
    localparam logic [1:0] SEL_HIGH_B    = 2'd3;
endpackage

// File: rtl/blkrep_cond.sv
module blkrep_cond
    import blkrep_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic [1:0]         sel,
    input  logic               repeat_en,
    input  logic [2*REG_W-1:0] bc,
    input  logic               zf,
    output logic               take_rep,
    output logic               load_wz
);
    logic pair_nz;
    logic high_nz;
    logic cond;

    assign pair_nz = |bc;
    assign high_nz = |bc[2*REG_W-1:REG_W];

    always_comb begin
        cond    = 1'b0;
        load_wz = 1'b0;
        unique case (sel)
            SEL_PAIR: begin
                cond    = pair_nz;
                load_wz = 1'b1;
            end
            SEL_PAIR_NZ: begin
                cond    = pair_nz && !zf;
                load_wz = 1'b1;
            end
            SEL_HIGH_A,
            SEL_HIGH_B: begin
                cond    = high_nz;
                load_wz = 1'b0;
            end
            default: begin
                cond    = 1'b0;
                load_wz = 1'b0;
            end
        endcase
    end

    assign take_rep = repeat_en && cond;
endmodule

// File: rtl/blkrep_seq.sv
module blkrep_seq
    import blkrep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eval,
    input  logic take_rep,
    output logic start,
    output logic busy,
    output logic pc_dec,
    output logic fetch_go
);
    seq_state_t state_q;
    seq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (eval && take_rep) state_d = ST_GAP1;
            ST_GAP1:  state_d = ST_DEC1;
            ST_DEC1:  state_d = ST_GAP2;
            ST_GAP2:  state_d = ST_DEC2;
            ST_DEC2:  state_d = ST_FETCH;
            ST_FETCH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        start    = 1'b0;
        busy     = 1'b1;
        pc_dec   = 1'b0;
        fetch_go = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy     = 1'b0;
                start    = eval && take_rep;
                fetch_go = eval && !take_rep;
            end
            ST_DEC1,
            ST_DEC2:  pc_dec   = 1'b1;
            ST_FETCH: fetch_go = 1'b1;
            default: begin
                start    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/blkrep_addr.sv
module blkrep_addr #(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            load_wz,
    input  logic            pc_dec,
    input  logic            busy,
    input  logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] pc_value,
    output logic [PC_W-1:0] wz_q
);
    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    logic [PC_W-1:0] pc_work;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_work <= '0;
            wz_q    <= '0;
        end else begin
            if (start)       pc_work <= pc;
            else if (pc_dec) pc_work <= pc_work - ONE;
            if (start && load_wz) wz_q <= pc + ONE;
        end
    end

    assign pc_value = busy ? pc_work : pc;
endmodule

// File: rtl/block_repeat_unit.sv
module block_repeat_unit #(
    parameter int REG_W = 8,
    parameter int PC_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               eval,
    input  logic [1:0]         sel,
    input  logic               repeat_en,
    input  logic [2*REG_W-1:0] bc,
    input  logic               zf,
    input  logic [PC_W-1:0]    pc,
    input  logic               irq_pend,
    output logic               rep_taken,
    output logic               busy,
    output logic               pc_dec,
    output logic               fetch_go,
    output logic [PC_W-1:0]    pc_value,
    output logic [PC_W-1:0]    wz_q,
    output logic               irq_take
);
    logic take_rep;
    logic load_wz;
    logic start;

    blkrep_cond #(.REG_W(REG_W)) cond_i (
        .sel       (sel),
        .repeat_en (repeat_en),
        .bc        (bc),
        .zf        (zf),
        .take_rep  (take_rep),
        .load_wz   (load_wz)
    );

    blkrep_seq seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .eval     (eval),
        .take_rep (take_rep),
        .start    (start),
        .busy     (busy),
        .pc_dec   (pc_dec),
        .fetch_go (fetch_go)
    );

    blkrep_addr #(.PC_W(PC_W)) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load_wz  (load_wz),
        .pc_dec   (pc_dec),
        .busy     (busy),
        .pc       (pc),
        .pc_value (pc_value),
        .wz_q     (wz_q)
    );

    assign rep_taken = start;
    assign irq_take  = fetch_go && irq_pend;
endmodule

// File: rtl/blkrep_chk.sv
module blkrep_chk #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            eval,
    input logic            rep_taken,
    input logic            busy,
    input logic            pc_dec,
    input logic            fetch_go,
    input logic            irq_pend,
    input logic            irq_take,
    input logic [PC_W-1:0] pc,
    input logic [PC_W-1:0] pc_value,
    input logic [PC_W-1:0] wz_q
);
    // R6
    pc_dec_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_dec |=> !pc_dec);

    // R6
    rewind_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_taken |=> (busy && !pc_dec && !fetch_go));

    // R6
    dec_in_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_dec |-> (busy && !fetch_go));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rep_taken);

    // R7
    wz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rep_taken |=> $stable(wz_q));

    // R8
    pass_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_go && !busy) |-> (pc_value == pc));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !busy && !rep_taken) |-> fetch_go);

    // R9
    irq_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (fetch_go && irq_pend));
endmodule

bind block_repeat_unit blkrep_chk #(.PC_W(PC_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval      (eval),
    .rep_taken (rep_taken),
    .busy      (busy),
    .pc_dec    (pc_dec),
    .fetch_go  (fetch_go),
    .irq_pend  (irq_pend),
    .irq_take  (irq_take),
    .pc        (pc),
    .pc_value  (pc_value),
    .wz_q      (wz_q)
);

// File: tb/block_repeat_unit_test.sv
module block_repeat_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        eval;
    logic [1:0]  sel;
    logic        repeat_en;
    logic [15:0] bc;
    logic        zf;
    logic [15:0] pc;
    logic        irq_pend;
    logic        rep_taken;
    logic        busy;
    logic        pc_dec;
    logic        fetch_go;
    logic [15:0] pc_value;
    logic [15:0] wz_q;
    logic        irq_take;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [15:0] wz_model = 16'h0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    block_repeat_unit uut (
        .clk(clk), .rst_n(rst_n), .eval(eval), .sel(sel), .repeat_en(repeat_en),
        .bc(bc), .zf(zf), .pc(pc), .irq_pend(irq_pend), .rep_taken(rep_taken),
        .busy(busy), .pc_dec(pc_dec), .fetch_go(fetch_go), .pc_value(pc_value),
        .wz_q(wz_q), .irq_take(irq_take)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit exp_rep(input logic [1:0] s, input logic en,
                                   input logic [15:0] b, input logic z);
        if (!en) return 1'b0;
        case (s)
            2'd0:    return b != 16'h0;
            2'd1:    return (b != 16'h0) && !z;
            default: return b[15:8] != 8'h0;
        endcase
    endfunction

    function automatic string rtag(input logic [1:0] s, input logic en);
        if (!en) return "R5";
        case (s)
            2'd0:    return "R2";
            2'd1:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic run_case(input logic [1:0] s, input logic en, input logic [15:0] b,
                            input logic z, input logic [15:0] p, input logic irq);
        bit exp;
        exp = exp_rep(s, en, b, z);
        @(negedge clk);
        eval = 1'b1; sel = s; repeat_en = en; bc = b; zf = z; pc = p; irq_pend = irq;
        #1;
        chk(rep_taken == exp, rtag(s, en), {31'b0, rep_taken}, {31'b0, exp});
        if (!exp) begin
            chk(fetch_go == 1'b1 && pc_value == p, "R8", {15'b0, fetch_go, pc_value},
                {15'b0, 1'b1, p});
            chk(irq_take == irq, "R9", {31'b0, irq_take}, {31'b0, irq});
            @(negedge clk);
            eval = 1'b0;
            #1;
            chk(busy == 1'b0, en ? "R8" : "R5", {31'b0, busy}, 32'h0);
            chk(wz_q == wz_model, "R7", {16'b0, wz_q}, {16'b0, wz_model});
        end else begin
            if (s < 2'd2) wz_model = p + 16'd1;
            for (int k = 1; k <= 5; k++) begin
                @(negedge clk);
                if (k < 5) begin
                    eval = 1'b1; sel = 2'($urandom); repeat_en = 1'b1;
                    bc = 16'($urandom) | 16'h0100; zf = 1'b0; pc = 16'($urandom);
                    irq_pend = 1'b1;
                end else begin
                    eval = 1'b0; irq_pend = irq; pc = 16'($urandom);
                end
                #1;
                chk(busy == 1'b1, "R6", {31'b0, busy}, 32'h1);
                chk(rep_taken == 1'b0, "R10", {31'b0, rep_taken}, 32'h0);
                chk(pc_dec == (k == 2 || k == 4), "R6", {31'b0, pc_dec},
                    {31'b0, (k == 2 || k == 4)});
                if (k < 5) begin
                    chk(fetch_go == 1'b0 && irq_take == 1'b0, "R9",
                        {30'b0, fetch_go, irq_take}, 32'h0);
                end else begin
                    chk(fetch_go == 1'b1 && pc_value == p - 16'd2, "R6",
                        {15'b0, fetch_go, pc_value}, {15'b0, 1'b1, p - 16'd2});
                    chk(irq_take == irq, "R9", {31'b0, irq_take}, {31'b0, irq});
                end
                chk(wz_q == wz_model, "R7", {16'b0, wz_q}, {16'b0, wz_model});
            end
            @(negedge clk);
            eval = 1'b0; irq_pend = 1'b0;
            #1;
            chk(busy == 1'b0 && fetch_go == 1'b0, "R6", {30'b0, busy, fetch_go}, 32'h0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1357));
        rst_n = 1'b0; eval = 1'b0; sel = 2'd0; repeat_en = 1'b0; bc = 16'h0;
        zf = 1'b0; pc = 16'h0; irq_pend = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R1
        chk(busy == 0 && pc_dec == 0 && fetch_go == 0 && rep_taken == 0 && irq_take == 0,
            "R1", {27'b0, busy, pc_dec, fetch_go, rep_taken, irq_take}, 32'h0);
        chk(wz_q == 16'h0, "R1", {16'b0, wz_q}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        run_case(2'd0, 1'b1, 16'h0000, 1'b0, 16'h1234, 1'b1);  // R2 no repeat
        run_case(2'd0, 1'b1, 16'h0001, 1'b1, 16'h4000, 1'b0);  // R2 repeat, R7 load
        run_case(2'd1, 1'b1, 16'h0005, 1'b1, 16'h2000, 1'b0);  // R3 zf stops
        run_case(2'd1, 1'b1, 16'h0005, 1'b0, 16'hFFFF, 1'b1);  // R3 repeat, wz wrap
        run_case(2'd2, 1'b1, 16'h00FF, 1'b0, 16'h3000, 1'b0);  // R4 B zero
        run_case(2'd3, 1'b1, 16'h0100, 1'b1, 16'h0001, 1'b1);  // R4 repeat, pc wrap, wz kept
        run_case(2'd0, 1'b0, 16'hFFFF, 1'b0, 16'h5555, 1'b1);  // R5 single-shot
        run_case(2'd2, 1'b0, 16'hFF00, 1'b0, 16'h6666, 1'b0);  // R5 single-shot

        for (int i = 0; i < 400; i++) begin
            logic [15:0] rb;
            rb = {(($urandom % 3) == 0) ? 8'h00 : 8'($urandom),
                  (($urandom % 2) == 0) ? 8'h00 : 8'($urandom)};
            run_case(2'($urandom), ($urandom % 5) != 0, rb, 1'($urandom),
                     16'($urandom), 1'($urandom));
        end
        finish_run();
    end
endmodule